// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block handles hardware handshaking for a single UART channel. On the receive side it compares the receive-FIFO fill level with a ladder of thresholds. It raises an interrupt request when the programmed trigger level is reached. It drives the RTS line with hysteresis: RTS goes high (stop) one rung above the trigger level and returns low only after the level falls below the rung under the trigger.

On the transmit side it resynchronises the asynchronous CTS input. It permits the start of a new character only when the serializer is idle and, if automatic CTS is enabled, CTS is low. A character that is already being shifted out is never affected. When automatic RTS is disabled, the RTS pin carries a software-supplied value. A two-bit status output shows the live state of both directions of flow control.

Top module: `fc_flow_ctl`

## Requirements
- R1: After reset the automatic RTS state is clear, `irq_o` is 0 and `fc_state_o` is 0.
- R2: With `auto_cts_en_i` = 0, `cts_i` has no effect: `tx_start_o` equals `tx_req_i & ~tx_busy_i`.
- R3: With `auto_cts_en_i` = 1, `tx_start_o` is 0 while synchronised CTS is 1. It follows `tx_req_i & ~tx_busy_i` again once synchronised CTS is 0.
- R4: `tx_start_o` is never 1 while `tx_busy_i` is 1, so a character in progress always completes.
- R5: A change on `cts_i` reaches the transmit gate after exactly two rising clock edges (two-flop synchroniser).
- R6: The threshold ladder for FIFO depth D is T0=D/8, T1=D/4, T2=D/2, T3=3D/4, T4=D. `trig_sel_i`=s selects the trigger level T(s+1).
- R7: `irq_o` is registered. One cycle after a sampled `rx_level_i >= T(s+1)` with auto-RTS on, it is 1. It is 0 whenever the sampled auto-RTS enable is 0.
- R8: With auto-RTS on, the RTS state becomes 1 one cycle after a sampled `rx_level_i >= T(min(s+2,4))`, and `rts_o` then reads 1.
- R9: Once set, the RTS state stays 1 until a sampled `rx_level_i < T(s)`, and becomes 0 on the following cycle. Levels between those two thresholds leave it unchanged.
- R10: With auto-RTS off, `rts_o` equals `sw_rts_i` combinationally, and the RTS state is cleared on the next edge.
- R11: `fc_state_o[0]` is the automatic RTS state. `fc_state_o[1]` is 1 when auto-CTS is enabled and synchronised CTS is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| auto_rts_en_i | input | 1 | Enable automatic RTS |
| auto_cts_en_i | input | 1 | Enable automatic CTS |
| trig_sel_i | input | 2 | Trigger level select |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| sw_rts_i | input | 1 | Software RTS value |
| cts_i | input | 1 | Asynchronous CTS line (1 = stop) |
| tx_req_i | input | 1 | Serializer has a character ready |
| tx_busy_i | input | 1 | Serializer is shifting a character |
| tx_start_o | output | 1 | Permission to start the next character |
| rts_o | output | 1 | RTS line (1 = stop) |
| irq_o | output | 1 | Trigger-level interrupt request |
| fc_state_o | output | 2 | Flow control status {tx stopped, rx throttled} |

## Verification
The hardest case to reach is the hysteresis band. Its hold behaviour shows only when the fill level falls through the region between T(s) and T(min(s+2,4)) after the RTS state has been set. The bench therefore drives every select value through a full ramp up to D and back down to 0, one step per cycle, so that each threshold is crossed in both directions. It also toggles CTS while the serializer is busy and idle, and checks the two-edge synchroniser delay at each transition.

// File: rtl/fc_pkg.sv
package fc_pkg;
  function automatic int unsigned fc_rung(input int unsigned idx, input int unsigned depth);
    case (idx)
      0:       return depth / 8;
      1:       return depth / 4;
      2:       return depth / 2;
      3:       return (3 * depth) / 4;
      default: return depth;
    endcase
  endfunction
endpackage

// File: rtl/fc_sync.sv
module fc_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/fc_rx_ctl.sv
module fc_rx_ctl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_rts_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [LVL_W-1:0] rx_level_i,
  output logic             hold_o,
  output logic             irq_o
);
  import fc_pkg::*;
  logic [LVL_W-1:0] thr_irq, thr_hi, thr_lo;
  logic hold_q, irq_q, hold_d;

  always_comb begin
    int unsigned s;
    s = 32'(trig_sel_i);
    thr_irq = LVL_W'(fc_rung(s + 1, DEPTH));
    thr_hi  = LVL_W'(fc_rung((s == 3) ? 4 : s + 2, DEPTH));
    thr_lo  = LVL_W'(fc_rung(s, DEPTH));
  end

  always_comb begin
    hold_d = hold_q;
    if (!auto_rts_en_i)           hold_d = 1'b0;
    else if (rx_level_i >= thr_hi) hold_d = 1'b1;
    else if (rx_level_i < thr_lo)  hold_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      irq_q  <= auto_rts_en_i && (rx_level_i >= thr_irq);
    end
  end

  assign hold_o = hold_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic auto_cts_en_i,
  input  logic cts_sync_i,
  input  logic tx_req_i,
  input  logic tx_busy_i,
  output logic stop_o,
  output logic tx_start_o
);
  assign stop_o     = auto_cts_en_i & cts_sync_i;
  // only gates the start of a character; a busy serializer is left alone
  assign tx_start_o = tx_req_i & ~tx_busy_i & ~stop_o;
endmodule

// File: rtl/fc_flow_ctl.sv
module fc_flow_ctl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_rts_en_i,
  input  logic             auto_cts_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             sw_rts_i,
  input  logic             cts_i,
  input  logic             tx_req_i,
  input  logic             tx_busy_i,
  output logic             tx_start_o,
  output logic             rts_o,
  output logic             irq_o,
  output logic [1:0]       fc_state_o
);
  logic cts_s, hold, tx_stop;

  fc_sync u_cts_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cts_i),
    .q_o   (cts_s)
  );

  fc_rx_ctl #(.DEPTH(DEPTH)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .auto_rts_en_i(auto_rts_en_i),
    .trig_sel_i   (trig_sel_i),
    .rx_level_i   (rx_level_i),
    .hold_o       (hold),
    .irq_o        (irq_o)
  );

  fc_tx_gate u_tx (
    .auto_cts_en_i(auto_cts_en_i),
    .cts_sync_i   (cts_s),
    .tx_req_i     (tx_req_i),
    .tx_busy_i    (tx_busy_i),
    .stop_o       (tx_stop),
    .tx_start_o   (tx_start_o)
  );

  assign rts_o      = auto_rts_en_i ? hold : sw_rts_i;
  assign fc_state_o = {tx_stop, hold};
endmodule

// File: rtl/fc_flow_ctl_chk.sv
module fc_flow_ctl_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             auto_rts_en_i,
  input logic             auto_cts_en_i,
  input logic [1:0]       trig_sel_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic             tx_req_i,
  input logic             tx_busy_i,
  input logic             tx_start_o,
  input logic             irq_o,
  input logic [1:0]       fc_state_o
);
  import fc_pkg::*;
  logic [LVL_W-1:0] lo_thr;
  assign lo_thr = LVL_W'(fc_rung(32'(trig_sel_i), DEPTH));

  // R4
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |-> !tx_start_o);
  // R3
  start_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> tx_req_i);
  // R7
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_rts_en_i |=> !irq_o);
  // R10
  hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_rts_en_i |=> !fc_state_o[0]);
  // R9
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_state_o[0] && auto_rts_en_i && rx_level_i >= lo_thr) |=> fc_state_o[0]);
  // R11
  cts_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_cts_en_i |-> !fc_state_o[1]);
endmodule

bind fc_flow_ctl fc_flow_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .auto_rts_en_i(auto_rts_en_i),
  .auto_cts_en_i(auto_cts_en_i),
  .trig_sel_i   (trig_sel_i),
  .rx_level_i   (rx_level_i),
  .tx_req_i     (tx_req_i),
  .tx_busy_i    (tx_busy_i),
  .tx_start_o   (tx_start_o),
  .irq_o        (irq_o),
  .fc_state_o   (fc_state_o)
);

// File: tb/fc_flow_ctl_test.sv
`timescale 1ns/1ps
module fc_flow_ctl_test;
  localparam int D = 16;
  localparam int LW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_rts = 0, auto_cts = 0, sw_rts = 0, cts = 0, req = 0, busy = 0;
  logic [1:0] sel = 0;
  logic [LW-1:0] lvl = 0;
  logic tx_start, rts, irq;
  logic [1:0] st;

  int errors = 0, checks = 0;
  bit m_hold = 0, m_irq = 0, m_s1 = 0, m_s2 = 0;

  always #4 clk = ~clk;

  fc_flow_ctl #(.DEPTH(D)) uut (
    .clk_i(clk), .rst_ni(rst_n), .auto_rts_en_i(auto_rts), .auto_cts_en_i(auto_cts),
    .trig_sel_i(sel), .rx_level_i(lvl), .sw_rts_i(sw_rts), .cts_i(cts),
    .tx_req_i(req), .tx_busy_i(busy), .tx_start_o(tx_start), .rts_o(rts),
    .irq_o(irq), .fc_state_o(st)
  );

  function automatic int rung(int i);
    if (i == 0) return D / 8;
    if (i >= 4) return D;
    return i * D / 4;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int s;
    @(posedge clk);
    s = sel;
    m_s2 = m_s1;
    m_s1 = cts;
    m_irq = auto_rts && (lvl >= rung(s + 1));
    if (!auto_rts) m_hold = 0;
    else if (lvl >= rung((s + 2 > 4) ? 4 : s + 2)) m_hold = 1;
    else if (lvl < rung(s)) m_hold = 0;
    #1;
    chk("R7 irq", irq, m_irq);
    chk("R8 R9 R10 rts", rts, auto_rts ? m_hold : sw_rts);
    chk("R11 state0", st[0], m_hold);
    chk("R11 state1", st[1], auto_cts & m_s2);
    chk("R2 R3 R4 R5 start", tx_start, req & ~busy & ~(auto_cts & m_s2));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #21;
    // R1
    chk("R1 irq", irq, 0);
    chk("R1 state", st, 0);
    chk("R1 rts", rts, sw_rts);
    rst_n = 1'b1;
    #3;
    // R2 R3 R4 R5: CTS sweep with all req/busy combos
    for (int ac = 0; ac < 2; ac++) begin
      auto_cts = ac[0];
      for (int c = 0; c < 8; c++) begin
        cts = c[0];
        for (int k = 0; k < 4; k++) begin
          req = k[0]; busy = k[1];
          step();
        end
      end
    end
    // R5: exact two-edge latency
    auto_cts = 1; req = 1; busy = 0; cts = 0;
    repeat (3) step();
    cts = 1;
    step(); chk("R5 edge1", tx_start, 1);
    step(); chk("R5 edge2", tx_start, 0);
    cts = 0;
    step(); chk("R5 back1", tx_start, 0);
    step(); chk("R5 back2", tx_start, 1);
    auto_cts = 0;
    // R6 R7 R8 R9 R10: ramps for every select
    for (int ar = 0; ar < 2; ar++) begin
      auto_rts = ar[0];
      for (int s = 0; s < 4; s++) begin
        sel = 2'(s);
        sw_rts = s[0];
        for (int l = 0; l <= D; l++) begin lvl = LW'(l); step(); end
        for (int l = D; l >= 0; l--) begin lvl = LW'(l); step(); end
        for (int l = 0; l <= D; l += 3) begin lvl = LW'(l); step(); end
        for (int l = D; l >= 0; l -= 5) begin lvl = LW'(l); step(); end
      end
    end
    // R9 hysteresis band, sel=1: set at T3=12, hold until <T1=4
    auto_rts = 1; sel = 1;
    lvl = 12; step(); chk("R8 set", rts, 1);
    lvl = 4;  step(); chk("R9 hold", rts, 1);
    lvl = 3;  step(); chk("R9 clear", rts, 0);
    // R10 auto off passes sw value, clears state
    lvl = 16; step();
    auto_rts = 0; sw_rts = 0;
    #1 chk("R10 comb", rts, 0);
    step(); chk("R10 cleared", st[0], 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule